// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block drives a raw 8-bit NAND flash bus shared by several chip-select banks and carries out one flash operation at a time: page read, page program, block erase, device reset or identifier read. A request names the operation, the bank, a 16-bit page address and whether the main area, the spare area or both take part. The sequencer then produces the command-latch, address-latch and data strobe cycles in the right order. On each strobe cycle it either presents a byte or samples one.

After a read, program or erase the sequencer does not watch the ready/busy pin. It issues the status command and reads the status byte repeatedly until the ready bit is set. It then re-enters array-read mode so that the data reads that follow return page contents. Data moves through a byte stream in each direction with valid/ready handshakes. The end of every operation is marked by a single-clock done or timeout pulse. The width of the write and read strobes can be set for each bank separately.

Top module: `nand_op_seq`

## Requirements
- R1: While reset is held and after it is released with no request, every chip select, `nand_we_n` and `nand_re_n` are high, `nand_cle` and `nand_ale` are low, and `busy`, `done`, `timeout` and `rd_valid` are low.
- R2: A page read (`req_op`=0) with main and spare selected emits command 0x00, four address bytes (column low, column high, page low, page high; column 0), command 0x30, command 0x70, status reads until bit 6 of the status byte is set, and command 0x00. It then reads MAIN_BYTES+SPARE_BYTES bytes and delivers each on `rd_data` with `rd_valid`, holding each byte until `rd_ready`.
- R3: When the main area is not selected, the column address sent is MAIN_BYTES and only the SPARE_BYTES spare bytes are transferred.
- R4: A page program (`req_op`=1) emits 0x80, the four address bytes, one write strobe per byte taken from the `wr_data` stream (main then spare, in stream order), 0x10, and then the same status poll ending in 0x00 as a read.
- R5: A block erase (`req_op`=2) emits 0x60, two address bytes (page low, page high), 0xD0, and the status poll ending in 0x00.
- R6: A reset (`req_op`=3) emits 0xFF and then waits, without further strobes, until the selected bank's `nand_rb_n` bit is high. It then pulses `done`, or pulses `timeout` after RB_LIMIT clocks.
- R7: An identifier read (`req_op`=4) emits 0x90, a single address byte 0x00, and then reads ID_BYTES bytes onto the read stream.
- R8: If POLL_LIMIT status reads pass without bit 6 set, the operation ends with a `timeout` pulse, no 0x00 follows, and no data moves.
- R9: Only the requested bank's chip select is low during an operation. Each write or read strobe is low for the bank's programmed width in clocks (a width of 0 counts as 1), and every bank's width is 7 after reset. The byte on `nand_dq_o` is stable throughout a write strobe.
- R10: A request made while `busy` is high is ignored. Each operation ends with exactly one of `done` or `timeout`, high for exactly one clock, and `busy` is low in that clock.
- R11: `nand_we_n` and `nand_re_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start an operation (taken when idle) |
| req_op | input | 3 | 0 read, 1 program, 2 erase, 3 reset, 4 identifier read |
| req_bank | input | BW | Target bank |
| req_page | input | 16 | Page (row) address |
| req_main | input | 1 | Main area takes part |
| req_spare | input | 1 | Spare area takes part |
| cfg_we | input | 1 | Write a strobe width |
| cfg_bank | input | BW | Bank whose width is written |
| cfg_pulse | input | PW_BITS | Strobe low width in clocks |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock pulse on normal completion |
| timeout | output | 1 | One-clock pulse when a wait limit expires |
| nand_ce_n | output | NBANK | Chip selects, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Byte driven to the flash |
| nand_dq_oe | output | 1 | Output enable for nand_dq_o |
| nand_dq_i | input | 8 | Byte from the flash |
| nand_rb_n | input | NBANK | Per-bank ready/busy, high when ready |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program data available |
| wr_ready | output | 1 | Sequencer takes wr_data this clock |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | rd_data holds a byte |
| rd_ready | input | 1 | Consumer takes rd_data |

## Verification
The bench builds the sequencer with MAIN_BYTES=8, SPARE_BYTES=4, ID_BYTES=4, POLL_LIMIT=5 and RB_LIMIT=64. These values keep complete page transfers short enough to compare every strobe against an expected command, address and data list. They also let a stuck status byte run the poll into its limit within a few dozen clocks. The default strobe width of 7 and a reprogrammed width of 2 are both measured on the bus.

// File: rtl/nand_op_seq.sv
module nand_op_seq #(
  parameter int MAIN_BYTES  = 2048,
  parameter int SPARE_BYTES = 64,
  parameter int ID_BYTES    = 4,
  parameter int POLL_LIMIT  = 16384,
  parameter int RB_LIMIT    = 262144,
  parameter int NBANK       = 4,
  parameter int PW_BITS     = 4,
  localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [2:0]         req_op,
  input  logic [BW-1:0]      req_bank,
  input  logic [15:0]        req_page,
  input  logic               req_main,
  input  logic               req_spare,
  input  logic               cfg_we,
  input  logic [BW-1:0]      cfg_bank,
  input  logic [PW_BITS-1:0] cfg_pulse,
  output logic               busy,
  output logic               done,
  output logic               timeout,
  output logic [NBANK-1:0]   nand_ce_n,
  output logic               nand_cle,
  output logic               nand_ale,
  output logic               nand_we_n,
  output logic               nand_re_n,
  output logic [7:0]         nand_dq_o,
  output logic               nand_dq_oe,
  input  logic [7:0]         nand_dq_i,
  input  logic [NBANK-1:0]   nand_rb_n,
  input  logic [7:0]         wr_data,
  input  logic               wr_valid,
  output logic               wr_ready,
  output logic [7:0]         rd_data,
  output logic               rd_valid,
  input  logic               rd_ready
);
  localparam int LW   = $clog2(MAIN_BYTES + SPARE_BYTES + ID_BYTES + 1);
  localparam int WMAX = (POLL_LIMIT > RB_LIMIT) ? POLL_LIMIT : RB_LIMIT;
  localparam int CW   = $clog2(WMAX + 1);
  localparam int TW   = PW_BITS + 2;

  localparam logic [2:0] OP_READ = 3'd0, OP_PROG = 3'd1, OP_ERASE = 3'd2,
                         OP_RESET = 3'd3, OP_ID = 3'd4;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD1, S_ADDR, S_XFER, S_CMD2, S_STCMD, S_STRD, S_RDMODE, S_RBWAIT
  } state_t;

  state_t             st;
  logic [2:0]         op_q;
  logic [BW-1:0]      bank_q;
  logic [15:0]        page_q;
  logic [15:0]        col_q;
  logic [LW-1:0]      len_q;
  logic [LW-1:0]      idx;
  logic [CW-1:0]      wcnt;
  logic               act;
  logic [TW-1:0]      tcnt;
  logic [7:0]         wbyte_q;
  logic [7:0]         rd_q;
  logic               rdv_q;
  logic               st_rdy;
  logic               done_q, to_q;
  logic [PW_BITS-1:0] twp [NBANK];

  logic [TW-1:0] pw;
  logic [2:0]    nadr;
  logic [7:0]    cmd_byte, adr_byte;
  logic          is_cmd, is_rd_cyc, is_wr_data, bus_st, go, samp, last;

  assign pw = (twp[bank_q] == '0) ? TW'(1) : TW'(twp[bank_q]);

  assign is_cmd     = (st == S_CMD1) || (st == S_CMD2) || (st == S_STCMD) || (st == S_RDMODE);
  assign is_wr_data = (st == S_XFER) && (op_q == OP_PROG);
  assign is_rd_cyc  = (st == S_STRD) || ((st == S_XFER) && (op_q != OP_PROG));
  assign bus_st     = (st != S_IDLE) && (st != S_RBWAIT);
  assign go   = !act && bus_st && (!is_wr_data || wr_valid) &&
                !((st == S_XFER) && (op_q != OP_PROG) && rdv_q);
  assign samp = act && (tcnt == pw - TW'(1));
  assign last = act && (tcnt == (pw << 1) - TW'(1));

  always_comb begin
    case (op_q)
      OP_ERASE: nadr = 3'd2;
      OP_ID:    nadr = 3'd1;
      default:  nadr = 3'd4;
    endcase
    case (op_q)
      OP_ERASE: adr_byte = (idx == '0) ? page_q[7:0] : page_q[15:8];
      OP_ID:    adr_byte = 8'h00;
      default:
        case (idx[1:0])
          2'd0:    adr_byte = col_q[7:0];
          2'd1:    adr_byte = col_q[15:8];
          2'd2:    adr_byte = page_q[7:0];
          default: adr_byte = page_q[15:8];
        endcase
    endcase
    cmd_byte = 8'h00;
    case (st)
      S_CMD1:
        case (op_q)
          OP_PROG:  cmd_byte = 8'h80;
          OP_ERASE: cmd_byte = 8'h60;
          OP_RESET: cmd_byte = 8'hFF;
          OP_ID:    cmd_byte = 8'h90;
          default:  cmd_byte = 8'h00;
        endcase
      S_CMD2:
        case (op_q)
          OP_PROG:  cmd_byte = 8'h10;
          OP_ERASE: cmd_byte = 8'hD0;
          default:  cmd_byte = 8'h30;
        endcase
      S_STCMD: cmd_byte = 8'h70;
      default: cmd_byte = 8'h00;
    endcase
  end

  assign busy       = (st != S_IDLE);
  assign done       = done_q;
  assign timeout    = to_q;
  assign nand_cle   = act && is_cmd;
  assign nand_ale   = act && (st == S_ADDR);
  assign nand_we_n  = !(act && (tcnt < pw) && !is_rd_cyc);
  assign nand_re_n  = !(act && (tcnt < pw) && is_rd_cyc);
  assign nand_dq_oe = act && !is_rd_cyc;
  assign nand_dq_o  = is_cmd ? cmd_byte : (st == S_ADDR) ? adr_byte : wbyte_q;
  assign wr_ready   = is_wr_data && !act;
  assign rd_data    = rd_q;
  assign rd_valid   = rdv_q;

  for (genvar b = 0; b < NBANK; b++) begin : g_ce
    assign nand_ce_n[b] = !(busy && (bank_q == BW'(b)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op_q <= '0; bank_q <= '0; page_q <= '0; col_q <= '0;
      len_q <= '0; idx <= '0; wcnt <= '0; act <= 1'b0; tcnt <= '0;
      wbyte_q <= '0; rd_q <= '0; rdv_q <= 1'b0; st_rdy <= 1'b0;
      done_q <= 1'b0; to_q <= 1'b0;
      for (int b = 0; b < NBANK; b++) twp[b] <= PW_BITS'(7);
    end else begin
      done_q <= 1'b0;
      to_q   <= 1'b0;
      if (cfg_we) twp[cfg_bank] <= cfg_pulse;
      if (rdv_q && rd_ready) rdv_q <= 1'b0;

      if (st == S_IDLE) begin
        if (req_valid && req_op <= OP_ID) begin
          st <= S_CMD1; op_q <= req_op; bank_q <= req_bank; page_q <= req_page;
          idx <= '0;
          col_q <= req_main ? 16'h0 : 16'(MAIN_BYTES);
          if (req_op == OP_ID) len_q <= LW'(ID_BYTES);
          else if (req_op == OP_READ || req_op == OP_PROG)
            len_q <= (req_main ? LW'(MAIN_BYTES) : '0) + (req_spare ? LW'(SPARE_BYTES) : '0);
          else len_q <= '0;
        end
      end else if (st == S_RBWAIT) begin
        if (nand_rb_n[bank_q]) begin
          st <= S_IDLE; done_q <= 1'b1;
        end else if (wcnt == CW'(RB_LIMIT - 1)) begin
          st <= S_IDLE; to_q <= 1'b1;
        end else wcnt <= wcnt + 1'b1;
      end

      if (go) begin
        act <= 1'b1; tcnt <= '0;
        if (is_wr_data) wbyte_q <= wr_data;
      end else if (act) begin
        tcnt <= tcnt + 1'b1;
        if (samp && is_rd_cyc) begin
          if (st == S_STRD) st_rdy <= nand_dq_i[6];
          else begin rd_q <= nand_dq_i; rdv_q <= 1'b1; end
        end
        if (last) begin
          act <= 1'b0;
          case (st)
            S_CMD1:
              if (op_q == OP_RESET) begin st <= S_RBWAIT; wcnt <= '0; end
              else begin st <= S_ADDR; idx <= '0; end
            S_ADDR:
              if (idx == LW'(nadr - 3'd1)) begin
                idx <= '0;
                if (op_q == OP_ID) begin
                  if (len_q != '0) st <= S_XFER;
                  else begin st <= S_IDLE; done_q <= 1'b1; end
                end else if (op_q == OP_PROG && len_q != '0) st <= S_XFER;
                else st <= S_CMD2;
              end else idx <= idx + 1'b1;
            S_XFER:
              if (idx == len_q - 1'b1) begin
                idx <= '0;
                if (op_q == OP_PROG) st <= S_CMD2;
                else begin st <= S_IDLE; done_q <= 1'b1; end
              end else idx <= idx + 1'b1;
            S_CMD2:  st <= S_STCMD;
            S_STCMD: begin st <= S_STRD; wcnt <= '0; end
            S_STRD:
              if (st_rdy) st <= S_RDMODE;
              else if (wcnt == CW'(POLL_LIMIT - 1)) begin st <= S_IDLE; to_q <= 1'b1; end
              else wcnt <= wcnt + 1'b1;
            S_RDMODE:
              if (op_q == OP_READ && len_q != '0) begin st <= S_XFER; idx <= '0; end
              else begin st <= S_IDLE; done_q <= 1'b1; end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n)); // R11
  AST_CE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~nand_ce_n)); // R9
  AST_DQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n && $past(!nand_we_n)) |-> $stable(nand_dq_o)); // R9
  AST_CE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(nand_ce_n)); // R10
  AST_END_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (done || timeout) |=> !(done || timeout)); // R10
  AST_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (done || timeout) |-> (!busy && !(done && timeout))); // R10
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R2
endmodule

// File: tb/nand_op_seq_tb.sv
`timescale 1ns/1ps
module nand_op_seq_tb;
  localparam int MB = 8, SB = 4, IB = 4, PL = 5, RL = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0; logic [2:0] req_op = 0; logic [1:0] req_bank = 0;
  logic [15:0] req_page = 0; logic req_main = 0, req_spare = 0;
  logic cfg_we = 0; logic [1:0] cfg_bank = 0; logic [3:0] cfg_pulse = 0;
  logic busy, done, timeout, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [3:0] nand_ce_n; logic [3:0] nand_rb_n = 4'hF;
  logic [7:0] nand_dq_o, nand_dq_i, wr_data, rd_data;
  logic wr_ready, rd_valid, rd_ready = 1'b1;

  always #2.5 clk = ~clk;

  nand_op_seq #(.MAIN_BYTES(MB), .SPARE_BYTES(SB), .ID_BYTES(IB),
    .POLL_LIMIT(PL), .RB_LIMIT(RL), .NBANK(4), .PW_BITS(4)) u_dut (
    .clk, .rst_n, .req_valid, .req_op, .req_bank, .req_page, .req_main, .req_spare,
    .cfg_we, .cfg_bank, .cfg_pulse, .busy, .done, .timeout, .nand_ce_n,
    .nand_cle, .nand_ale, .nand_we_n, .nand_re_n, .nand_dq_o, .nand_dq_oe,
    .nand_dq_i, .nand_rb_n, .wr_data, .wr_valid(1'b1), .wr_ready,
    .rd_data, .rd_valid, .rd_ready);

  int checks = 0, fails = 0;
  int ev [64]; int n_ev = 0;
  int ex [64]; int n_ex = 0;
  int rdb [64]; int n_rd = 0;
  int stat_mode = 0, ridx = 0, busy_left = 0, stuck = 0, n_stat = 0, wcount = 0;
  int n_done = 0, n_to = 0, lowcnt = 0, last_low = 0, cyc = 0;
  logic [3:0] ce_seen = 4'hF;

  assign wr_data   = 8'hC0 + 8'(wcount);
  assign nand_dq_i = stat_mode != 0 ? ((stuck != 0 || busy_left > 0) ? 8'h00 : 8'h40)
                                    : 8'h5A + 8'(ridx);

  always @(posedge nand_we_n) if (rst_n === 1'b1 && nand_ce_n != 4'hF) begin
    if (nand_cle) begin
      if (n_ev < 64) ev[n_ev] = 32'h100 | int'(nand_dq_o);
      if (nand_dq_o == 8'h70) stat_mode = 1; else begin stat_mode = 0; ridx = 0; end
    end else if (nand_ale) begin
      if (n_ev < 64) ev[n_ev] = 32'h200 | int'(nand_dq_o);
    end else begin
      if (n_ev < 64) ev[n_ev] = 32'h300 | int'(nand_dq_o);
      wcount++;
    end
    n_ev++;
  end

  always @(posedge nand_re_n) if (rst_n === 1'b1) begin
    if (stat_mode != 0) begin n_stat++; if (busy_left > 0) busy_left--; end
    else ridx++;
  end

  always @(negedge clk) begin
    cyc++;
    if (rd_valid && rd_ready) begin if (n_rd < 64) rdb[n_rd] = int'(rd_data); n_rd++; end
    if (done) n_done++;
    if (timeout) n_to++;
    if (busy) ce_seen = nand_ce_n;
    if (!nand_we_n) lowcnt++;
    else if (lowcnt > 0) begin last_low = lowcnt; lowcnt = 0; end
  end

  task automatic check(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic push(input int v); ex[n_ex] = v; n_ex++; endtask
  task automatic push_poll(); push(32'h170); endtask

  task automatic check_events(input string r);
    int bad = -1;
    check({r, " event count"}, n_ev, n_ex);
    for (int i = 0; i < n_ex && i < n_ev; i++) if (bad < 0 && ev[i] != ex[i]) bad = i;
    if (bad >= 0) check({r, " event"}, ev[bad], ex[bad]);
    else check({r, " event sequence"}, 0, 0);
  endtask

  task automatic clear_log();
    n_ev = 0; n_ex = 0; n_rd = 0; n_stat = 0; wcount = 0; n_done = 0; n_to = 0;
    ce_seen = 4'hF; last_low = 0;
  endtask

  task automatic run_op(input logic [2:0] op, input logic [1:0] bk, input logic [15:0] pg,
                        input logic m, input logic s);
    int w = 0;
    clear_log();
    @(negedge clk);
    req_valid = 1; req_op = op; req_bank = bk; req_page = pg; req_main = m; req_spare = s;
    @(negedge clk);
    req_valid = 0;
    while (!done && !timeout && w < 20000) begin @(negedge clk); w++; end
    if (w >= 20000) check("R10 operation ended", 0, 1);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_state();
    check("R1 chip selects", int'(nand_ce_n), 4'hF);
    check("R1 strobes", int'({nand_we_n, nand_re_n, nand_cle, nand_ale}), 4'b1100);
    check("R1 status", int'({busy, done, timeout, rd_valid}), 0);
  endtask

  task automatic t_read_full();
    busy_left = 2; stuck = 0;
    run_op(3'd0, 2'd1, 16'h1234, 1, 1);
    push(32'h100); push(32'h200); push(32'h200); push(32'h234); push(32'h212);
    push(32'h130); push_poll(); push(32'h100);
    check_events("R2 read");
    check("R2 status reads", n_stat, 3);
    check("R2 byte count", n_rd, MB + SB);
    for (int i = 0; i < MB + SB; i++) if (rdb[i] != ((8'h5A + i) & 8'hFF))
      check("R2 read data", rdb[i], (8'h5A + i) & 8'hFF);
    check("R2 last byte", rdb[MB+SB-1], (8'h5A + MB + SB - 1) & 8'hFF);
    check("R9 bank1 select", int'(ce_seen), 4'b1101);
    check("R9 default width", last_low, 7);
    check("R10 done pulses", n_done, 1);
    check("R10 timeout pulses", n_to, 0);
  endtask

  task automatic t_read_spare();
    busy_left = 0; stuck = 0;
    run_op(3'd0, 2'd0, 16'h0002, 0, 1);
    push(32'h100); push(32'h200 | MB); push(32'h200); push(32'h202); push(32'h200);
    push(32'h130); push_poll(); push(32'h100);
    check_events("R3 spare read");
    check("R3 byte count", n_rd, SB);
    check("R3 first byte", rdb[0], 8'h5A);
  endtask

  task automatic t_program();
    busy_left = 1; stuck = 0;
    run_op(3'd1, 2'd0, 16'hA55A, 1, 1);
    push(32'h180); push(32'h200); push(32'h200); push(32'h25A); push(32'h2A5);
    for (int i = 0; i < MB + SB; i++) push(32'h300 | ((8'hC0 + i) & 8'hFF));
    push(32'h110); push_poll(); push(32'h100);
    check_events("R4 program");
    check("R4 status reads", n_stat, 2);
    check("R4 done", n_done, 1);
  endtask

  task automatic t_erase();
    busy_left = 0; stuck = 0;
    cfg_we = 1; cfg_bank = 2'd3; cfg_pulse = 4'd2;
    @(negedge clk); cfg_we = 0;
    run_op(3'd2, 2'd3, 16'hBEEF, 0, 0);
    push(32'h160); push(32'h2EF); push(32'h2BE); push(32'h1D0); push_poll(); push(32'h100);
    check_events("R5 erase");
    check("R9 programmed width", last_low, 2);
    check("R9 bank3 select", int'(ce_seen), 4'b0111);
  endtask

  task automatic t_reset_op();
    int t0, t1;
    nand_rb_n = 4'b1011;
    fork
      begin repeat (30) @(negedge clk); nand_rb_n = 4'hF; end
    join_none
    t0 = cyc;
    run_op(3'd3, 2'd2, 16'h0, 0, 0);
    t1 = cyc;
    push(32'h1FF);
    check_events("R6 reset");
    check("R6 waited for ready", int'((t1 - t0) >= 30), 1);
    check("R6 done", n_done, 1);
    check("R6 no timeout", n_to, 0);
  endtask

  task automatic t_id();
    run_op(3'd4, 2'd0, 16'hFFFF, 0, 0);
    push(32'h190); push(32'h200);
    check_events("R7 id");
    check("R7 byte count", n_rd, IB);
    check("R7 last byte", rdb[IB-1], (8'h5A + IB - 1) & 8'hFF);
  endtask

  task automatic t_timeout();
    stuck = 1;
    run_op(3'd0, 2'd0, 16'h0304, 1, 0);
    push(32'h100); push(32'h200); push(32'h200); push(32'h204); push(32'h203);
    push(32'h130); push_poll();
    check_events("R8 timeout");
    check("R8 status reads", n_stat, PL);
    check("R8 timeout pulse", n_to, 1);
    check("R8 no done", n_done, 0);
    check("R8 no data", n_rd, 0);
    stuck = 0;
  endtask

  task automatic t_ignore_busy();
    busy_left = 3; stuck = 0;
    fork
      begin
        repeat (10) @(negedge clk);
        req_valid = 1; req_op = 3'd3; req_bank = 2'd1;
        @(negedge clk); req_valid = 0;
      end
    join_none
    run_op(3'd2, 2'd0, 16'h0102, 0, 0);
    repeat (20) @(negedge clk);
    push(32'h160); push(32'h202); push(32'h201); push(32'h1D0); push_poll(); push(32'h100);
    check_events("R10 request during busy ignored");
    check("R10 single completion", n_done, 1);
    check("R10 idle afterwards", int'(busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_read_full();
    t_read_spare();
    t_program();
    t_erase();
    t_reset_op();
    t_id();
    t_timeout();
    t_ignore_busy();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule